// File: doc/BRIEF.md
# Early Direct Branch Redirect Unit

This unit sits in the decode stage of a superscalar pipeline and checks the branch prediction of every instruction in a decode group before it moves on. For instructions that are both direct and unconditional control transfers, the correct successor address is already known from the encoded target, so the unit replaces the predicted next PC with that target. When the prediction disagrees, it sends a redirect to fetch instead of waiting for the execute stage to find the error.

An instruction that was predicted taken but is not a control transfer at all is also caught and takes the same recovery path. On any redirect, the unit cuts the decode group after the offending slot. It kills younger instructions arriving from fetch by comparing sequence numbers, and it tells the stage to drop its skid buffer. If the stage was stalled, it also sends an unblock pulse to fetch. Two wrapping event counters record resolved branches and redirects.

All outputs are registered. They reflect the inputs sampled at the previous rising clock edge.

Top module: `early_branch_redirect`

## Requirements
- R1: While `rst_n` is low, every output is zero, including both counters.
- R2: A forwarded slot that has `in_ctrl`, `in_direct` and `in_uncond` all set is a resolved slot. Its `out_npc` is `in_target`. Every other forwarded slot gets `in_pred_npc`. Outputs appear one cycle after the inputs.
- R3: A valid resolved slot whose `in_pred_npc` differs from `in_target` is a branch event. If it wins, the result is `redir_valid`=1, `redir_pc`=`in_target`, `redir_seq`=its sequence number and `redir_kind`=0.
- R4: A valid slot with `in_pred_taken`=1 and `in_ctrl`=0 is a control event. If it wins, the result is `redir_valid`=1, `redir_pc`=its PC + INST_BYTES, `redir_seq`=its sequence number and `redir_kind`=1.
- R5: When several slots have events, the lowest slot index wins and at most one redirect is raised per cycle. The winning slot is still forwarded. Valid slots with a higher index are cleared in `out_valid`. With no event, `out_valid` equals `in_valid`.
- R6: On a redirect, bit j of `fch_kill` is set exactly when `fch_valid[j]` is set and `fch_seq[j]` is greater than `redir_seq`, compared as unsigned numbers. Without a redirect, `fch_kill` is zero.
- R7: `skid_clear` is high in exactly the cycles in which `redir_valid` is high.
- R8: `unblock_fetch` pulses with a redirect only when `stage_state` was 1 (blocked) or 2 (unblocking). It stays low for 0 (running) and 3 (squashing).
- R9: `out_ready[i]` equals `in_no_src[i]` for a forwarded slot and is 0 for a slot that is not forwarded.
- R10: `cnt_resolved` grows by the number of resolved slots forwarded in a cycle. `cnt_mispred` grows by one per redirect. Both wrap at 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | W | Slot holds an instruction |
| in_pc | input | W*PC_W | Slot PC |
| in_ctrl | input | W | Slot is a control transfer |
| in_direct | input | W | Target is encoded in the instruction |
| in_uncond | input | W | Transfer is unconditional |
| in_target | input | W*PC_W | Encoded branch target |
| in_pred_taken | input | W | Predictor said taken |
| in_pred_npc | input | W*PC_W | Predicted next PC |
| in_seq | input | W*SEQ_W | Sequence number, rising with slot index |
| in_no_src | input | W | Instruction reads no source register |
| fch_valid | input | F | Incoming fetch entry valid |
| fch_seq | input | F*SEQ_W | Incoming fetch entry sequence number |
| stage_state | input | 2 | 0 running, 1 blocked, 2 unblocking, 3 squashing |
| out_valid | output | W | Slot forwarded to rename |
| out_npc | output | W*PC_W | Corrected next PC per slot |
| out_ready | output | W | Slot may issue without operands |
| redir_valid | output | 1 | Redirect to fetch (squash, mispredict, taken) |
| redir_pc | output | PC_W | Correct fetch address |
| redir_seq | output | SEQ_W | Sequence number of offending instruction |
| redir_kind | output | 1 | 0 wrong branch target, 1 non-control predicted taken |
| fch_kill | output | F | Squash mask for incoming fetch entries |
| skid_clear | output | 1 | Drop skid buffer contents |
| unblock_fetch | output | 1 | Release fetch from an earlier block |
| cnt_resolved | output | CNT_W | Resolved branch count |
| cnt_mispred | output | CNT_W | Redirect count |

## Verification
The assertions assume that reset is held across at least one clock edge. They also assume that sequence numbers grow with slot index and never wrap inside a window, so the unsigned compare for fetch kills stays meaningful. The stimulus builds each group from a random base with small increasing offsets and gives fetch entries offsets around that base, including one equal to an offending number. Predicted next PCs usually match the target, so both clean and mispredicted groups occur. Directed groups place events in several slots at once and in the last slot.

// File: rtl/early_branch_redirect.sv
module early_branch_redirect #(
  parameter int W          = 4,
  parameter int F          = 4,
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int CNT_W      = 16,
  parameter int INST_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [W-1:0]              in_valid,
  input  logic [W-1:0][PC_W-1:0]    in_pc,
  input  logic [W-1:0]              in_ctrl,
  input  logic [W-1:0]              in_direct,
  input  logic [W-1:0]              in_uncond,
  input  logic [W-1:0][PC_W-1:0]    in_target,
  input  logic [W-1:0]              in_pred_taken,
  input  logic [W-1:0][PC_W-1:0]    in_pred_npc,
  input  logic [W-1:0][SEQ_W-1:0]   in_seq,
  input  logic [W-1:0]              in_no_src,
  input  logic [F-1:0]              fch_valid,
  input  logic [F-1:0][SEQ_W-1:0]   fch_seq,
  input  logic [1:0]                stage_state,
  output logic [W-1:0]              out_valid,
  output logic [W-1:0][PC_W-1:0]    out_npc,
  output logic [W-1:0]              out_ready,
  output logic                      redir_valid,
  output logic [PC_W-1:0]           redir_pc,
  output logic [SEQ_W-1:0]          redir_seq,
  output logic                      redir_kind,
  output logic [F-1:0]              fch_kill,
  output logic                      skid_clear,
  output logic                      unblock_fetch,
  output logic [CNT_W-1:0]          cnt_resolved,
  output logic [CNT_W-1:0]          cnt_mispred
);
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
  localparam int RC_W  = $clog2(W + 1);

  logic [W-1:0] res, ev, keep;
  logic         hit;
  logic [IDX_W-1:0] idx;
  logic [RC_W-1:0]  rcnt;
  logic [F-1:0]     kill;
  logic [PC_W-1:0]  fix_pc;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      res[i] = in_valid[i] & in_ctrl[i] & in_direct[i] & in_uncond[i];
      ev[i]  = (res[i] & (in_pred_npc[i] != in_target[i])) |
               (in_valid[i] & in_pred_taken[i] & ~in_ctrl[i]);
    end
    hit = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--)
      if (ev[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    rcnt = '0;
    for (int i = 0; i < W; i++) begin
      keep[i] = in_valid[i] & (~hit | (IDX_W'(i) <= idx));
      rcnt    = rcnt + RC_W'(keep[i] & res[i]);
    end
    for (int j = 0; j < F; j++)
      kill[j] = hit & fch_valid[j] & (fch_seq[j] > in_seq[idx]);
    fix_pc = in_ctrl[idx] ? in_target[idx] : in_pc[idx] + PC_W'(INST_BYTES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= '0;
      out_npc       <= '0;
      out_ready     <= '0;
      redir_valid   <= 1'b0;
      redir_pc      <= '0;
      redir_seq     <= '0;
      redir_kind    <= 1'b0;
      fch_kill      <= '0;
      skid_clear    <= 1'b0;
      unblock_fetch <= 1'b0;
      cnt_resolved  <= '0;
      cnt_mispred   <= '0;
    end else begin
      out_valid <= keep;
      out_ready <= keep & in_no_src;
      for (int i = 0; i < W; i++)
        out_npc[i] <= !keep[i] ? '0 : (res[i] ? in_target[i] : in_pred_npc[i]);
      redir_valid   <= hit;
      redir_pc      <= hit ? fix_pc : '0;
      redir_seq     <= hit ? in_seq[idx] : '0;
      redir_kind    <= hit & ~in_ctrl[idx];
      fch_kill      <= kill;
      skid_clear    <= hit;
      unblock_fetch <= hit & (stage_state == 2'd1 || stage_state == 2'd2);
      cnt_resolved  <= cnt_resolved + CNT_W'(rcnt);
      cnt_mispred   <= cnt_mispred + CNT_W'(hit);
    end
  end

  p_kill_needs_redir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fch_kill != '0) |-> redir_valid);
  p_skid_with_redir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    skid_clear == redir_valid);
  p_unblock_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unblock_fetch |-> redir_valid && ($past(stage_state) == 2'd1 || $past(stage_state) == 2'd2));
  p_full_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid && $past(rst_n) |-> out_valid == $past(in_valid));
  p_mispred_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt_mispred == $past(cnt_mispred) + CNT_W'(redir_valid));
  p_ready_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready & ~out_valid) == '0);
endmodule

// File: tb/early_branch_redirect_tb.sv
module early_branch_redirect_tb_top;
  localparam int W = 4, F = 4, PC_W = 32, SEQ_W = 16, CNT_W = 16, IB = 4;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] in_valid, in_ctrl, in_direct, in_uncond, in_pred_taken, in_no_src;
  logic [W-1:0][PC_W-1:0] in_pc, in_target, in_pred_npc;
  logic [W-1:0][SEQ_W-1:0] in_seq;
  logic [F-1:0] fch_valid;
  logic [F-1:0][SEQ_W-1:0] fch_seq;
  logic [1:0] stage_state;
  logic [W-1:0] out_valid, out_ready;
  logic [W-1:0][PC_W-1:0] out_npc;
  logic redir_valid, redir_kind, skid_clear, unblock_fetch;
  logic [PC_W-1:0] redir_pc;
  logic [SEQ_W-1:0] redir_seq;
  logic [F-1:0] fch_kill;
  logic [CNT_W-1:0] cnt_resolved, cnt_mispred;

  int n_chk = 0, n_fail = 0;
  logic [CNT_W-1:0] m_res = 0, m_mis = 0;

  always #4 clk = ~clk;

  early_branch_redirect #(.W(W), .F(F), .PC_W(PC_W), .SEQ_W(SEQ_W),
    .CNT_W(CNT_W), .INST_BYTES(IB)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_res(int i);
    return in_valid[i] & in_ctrl[i] & in_direct[i] & in_uncond[i];
  endfunction

  function automatic bit is_ev(int i);
    return (is_res(i) && in_pred_npc[i] != in_target[i]) ||
           (in_valid[i] && in_pred_taken[i] && !in_ctrl[i]);
  endfunction

  task automatic step_and_check();
    int first = -1;
    logic [W-1:0] e_valid, e_ready;
    logic [F-1:0] e_kill;
    logic [PC_W-1:0] e_pc = 0;
    logic [SEQ_W-1:0] e_seq = 0;
    bit e_kind = 0, e_unb;
    int rc = 0;
    for (int i = W - 1; i >= 0; i--) if (is_ev(i)) first = i;
    for (int i = 0; i < W; i++) begin
      e_valid[i] = in_valid[i] && (first < 0 || i <= first);
      e_ready[i] = e_valid[i] & in_no_src[i];
      if (e_valid[i] && is_res(i)) rc++;
    end
    if (first >= 0) begin
      e_kind = !in_ctrl[first];
      e_pc   = e_kind ? in_pc[first] + IB : in_target[first];
      e_seq  = in_seq[first];
    end
    for (int j = 0; j < F; j++) e_kill[j] = first >= 0 && fch_valid[j] && fch_seq[j] > e_seq;
    e_unb = first >= 0 && (stage_state == 1 || stage_state == 2);
    m_res = m_res + CNT_W'(rc);
    m_mis = m_mis + CNT_W'(first >= 0);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == e_valid, "R5 out_valid", out_valid, e_valid);
    for (int i = 0; i < W; i++)
      if (e_valid[i])
        chk(out_npc[i] == (is_res(i) ? in_target[i] : in_pred_npc[i]), "R2 out_npc",
            out_npc[i], is_res(i) ? in_target[i] : in_pred_npc[i]);
    chk(out_ready == e_ready, "R9 out_ready", out_ready, e_ready);
    chk(redir_valid == (first >= 0), "R3 redir_valid", redir_valid, first >= 0);
    if (first >= 0) begin
      chk(redir_pc == e_pc, e_kind ? "R4 redir_pc" : "R3 redir_pc", redir_pc, e_pc);
      chk(redir_seq == e_seq, "R3 redir_seq", redir_seq, e_seq);
      chk(redir_kind == e_kind, "R4 redir_kind", redir_kind, e_kind);
    end
    chk(fch_kill == e_kill, "R6 fch_kill", fch_kill, e_kill);
    chk(skid_clear == (first >= 0), "R7 skid_clear", skid_clear, first >= 0);
    chk(unblock_fetch == e_unb, "R8 unblock_fetch", unblock_fetch, e_unb);
    chk(cnt_resolved == m_res, "R10 cnt_resolved", cnt_resolved, m_res);
    chk(cnt_mispred == m_mis, "R10 cnt_mispred", cnt_mispred, m_mis);
  endtask

  task automatic rand_group();
    logic [SEQ_W-1:0] base = SEQ_W'($urandom_range(100, 60000));
    for (int i = 0; i < W; i++) begin
      in_valid[i]      = ($urandom_range(0, 7) != 0);
      in_pc[i]         = $urandom & ~32'h3;
      in_ctrl[i]       = $urandom_range(0, 1);
      in_direct[i]     = ($urandom_range(0, 3) != 0);
      in_uncond[i]     = ($urandom_range(0, 3) != 0);
      in_target[i]     = $urandom & ~32'h3;
      in_pred_npc[i]   = ($urandom_range(0, 3) != 0) ? in_target[i] : in_pc[i] + IB;
      in_pred_taken[i] = ($urandom_range(0, 5) == 0);
      in_seq[i]        = base + SEQ_W'(i);
      in_no_src[i]     = $urandom_range(0, 1);
    end
    for (int j = 0; j < F; j++) begin
      fch_valid[j] = $urandom_range(0, 1);
      fch_seq[j]   = base + SEQ_W'($urandom_range(0, 7));
    end
    stage_state = 2'($urandom_range(0, 3));
  endtask

  task automatic clean_group();
    for (int i = 0; i < W; i++) begin
      in_valid[i] = 1; in_pc[i] = 32'h1000 + 32'(4 * i);
      in_ctrl[i] = 0; in_direct[i] = 0; in_uncond[i] = 0;
      in_target[i] = 32'h8000 + 32'(16 * i); in_pred_npc[i] = in_pc[i] + IB;
      in_pred_taken[i] = 0; in_seq[i] = SEQ_W'(50 + i); in_no_src[i] = 0;
    end
    fch_valid = '1;
    for (int j = 0; j < F; j++) fch_seq[j] = SEQ_W'(50 + j);
    stage_state = 0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    clean_group();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0 && redir_valid == 0 && fch_kill == 0 && skid_clear == 0 &&
        unblock_fetch == 0, "R1 reset outputs", {out_valid, redir_valid, fch_kill}, 0);
    chk(cnt_resolved == 0 && cnt_mispred == 0, "R1 reset counters", {cnt_resolved, cnt_mispred}, 0);
    rst_n = 1;

    clean_group();
    in_ctrl[1] = 1; in_direct[1] = 1; in_uncond[1] = 1; in_pred_npc[1] = in_target[1];
    step_and_check();  // R2 correct resolved branch, no redirect

    clean_group();
    in_pred_taken[1] = 1;
    in_ctrl[2] = 1; in_direct[2] = 1; in_uncond[2] = 1;
    stage_state = 1;
    step_and_check();  // R4 + R5 slot 1 beats slot 2, R8 blocked state, R6 equal seq kept

    clean_group();
    in_ctrl[W-1] = 1; in_direct[W-1] = 1; in_uncond[W-1] = 1;
    stage_state = 3;
    in_no_src = '1;
    step_and_check();  // R3 last slot, R8 squashing gives no pulse

    clean_group();
    in_ctrl[0] = 1; in_direct[0] = 1; in_uncond[0] = 1;
    in_pred_taken[1] = 1;
    stage_state = 2;
    step_and_check();  // R5 slot 0 wins, R8 unblocking

    clean_group();
    in_ctrl[0] = 1; in_direct[0] = 0; in_uncond[0] = 1;
    step_and_check();  // R2 indirect not resolved

    for (int k = 0; k < 400; k++) begin
      rand_group();
      step_and_check();
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule